// File: doc/BRIEF.md
# Extended I/O Interrupt Router

This block takes a wide vector of level-sensitive interrupt sources and steers each one to a processor core and an interrupt pin on that core. Sources are split into fixed-size groups. Each group has a pin-select byte, and each source has a core-select byte of its own. A global enable bitmap gates new requests. A per-core pending word array records which sources are currently raised toward each core. Software clears pending bits by writing ones. The per-core pin outputs are the OR of all pending sources that are routed to that pin.

Selector bytes are treated as one-hot nibbles. The lowest set bit of the low four bits picks the index, and a zero nibble picks index 0. A few word registers are plain storage that software can read and write; they have no effect on routing. All register accesses go through one synchronous port. Accesses are word-aligned, each byte lane has its own strobe, and data is little-endian.

Top module: `ext_irq_router`

## Requirements
- R1: After reset all outputs are 0, and every register (selectors, enables, pending words and plain storage) reads 0.
- R2: A group's pin is taken from the low nibble of its pin-select byte: the lowest set bit gives pin 0..3, a zero nibble gives pin 0, and bits 7:4 are ignored. Pins 4..7 of every core are never driven. Group g = source/32 and lives at byte 0x0C0+g.
- R3: A source's core is taken from the low nibble of its core-select byte at 0x800+source: the lowest set bit gives core 0..3, and a zero nibble gives core 0.
- R4: A rising source whose enable bit is 1 sets its pending bit in the selected core. Its pin output (core_irq bit core*8+pin) goes high two clock edges after the input change. A rising source whose enable bit is 0 sets nothing.
- R5: A falling source clears its pending bit in the currently selected core, and that pin drops when nothing else holds it.
- R6: Enable bytes live at 0x200+source/8, with bit source%8. Writing a 1-to-0 change retracts the pending bit as a fall would. Setting an enable bit back to 1 while the source is held high raises nothing, because there is no new edge.
- R7: Pending words are write-one-to-clear at 0x400 + core*0x100 + word*4, and only in enabled byte lanes. A cleared bit stays clear while its source stays high.
- R8: A pin output stays high while at least one pending source routed to it remains, and only drops when the last one is cleared.
- R9: Pending word w of core c holds sources w*32..w*32+31, with source w*32+b in bit b.
- R10: Node-type words at 0x0A0..0x0BF and bounce words at 0x280..0x29F read back what was written, per byte lane, and do not affect any output.
- R11: Reads of unmapped offsets (including pending-window offsets with bits 7:5 non-zero) return 0, and writes to them change nothing.
- R12: Read data appears on the clock edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 256 | Level interrupt sources |
| reg_addr | input | 12 | Byte offset of access (word-aligned) |
| reg_wdata | input | 32 | Write data, little-endian lanes |
| reg_be | input | 4 | Byte-lane write strobes |
| reg_we | input | 1 | Write enable |
| reg_rdata | output | 32 | Registered read data |
| core_irq | output | 32 | Pin lines, bit core*8+pin |

## Verification
The hardest situation to reach is a pending bit that has been cleared while its source is still held high. In that state the output must stay low until a genuine new edge arrives. The stimulus gets there by raising a source and holding it. It then either writes ones into the pending word or clears and restores the enable bit, and reads the pending word back through the port to confirm the bit stays clear. Shared-pin cases route sources from different groups onto one pin and release them one at a time.

// File: rtl/ext_irq_router_pkg.sv
package ext_irq_router_pkg;

  // region base offsets within the 12-bit window
  localparam int NT_BASE  = 32'h0A0;
  localparam int NT_WORDS = 8;
  localparam int PM_BASE  = 32'h0C0;
  localparam int EN_BASE  = 32'h200;
  localparam int BO_BASE  = 32'h280;
  localparam int ST_BASE  = 32'h400;
  localparam int ST_END   = 32'h800;
  localparam int CM_BASE  = 32'h800;

  // lowest set bit of a selector nibble; empty nibble selects 0
  function automatic logic [1:0] nib_pick(input logic [3:0] n);
    if (n[0])      return 2'd0;
    else if (n[1]) return 2'd1;
    else if (n[2]) return 2'd2;
    else if (n[3]) return 2'd3;
    else           return 2'd0;
  endfunction

endpackage

// File: rtl/ext_irq_router_regs.sv
module ext_irq_router_regs
  import ext_irq_router_pkg::*;
#(
  parameter int NUM_IRQ    = 256,
  parameter int GROUP_SIZE = 32,
  parameter int NUM_CORES  = 4,
  parameter int ADDR_W     = 12,
  localparam int NUM_GROUPS = NUM_IRQ / GROUP_SIZE,
  localparam int NUM_WORDS  = NUM_IRQ / 32,
  localparam int CORE_W     = $clog2(NUM_CORES),
  localparam int WORD_W     = $clog2(NUM_WORDS)
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic [ADDR_W-1:0]                    addr,
  input  logic [31:0]                          wdata,
  input  logic [3:0]                           be,
  input  logic                                 we,
  input  logic [NUM_CORES-1:0][NUM_IRQ-1:0]    st_q,
  output logic [31:0]                          rdata,
  output logic [NUM_IRQ-1:0]                   en_q,
  output logic [NUM_IRQ-1:0]                   en_drop,
  output logic [NUM_IRQ-1:0][CORE_W-1:0]       core_sel,
  output logic [NUM_GROUPS-1:0][1:0]           pin_sel,
  output logic                                 st_we,
  output logic [CORE_W-1:0]                    st_core,
  output logic [WORD_W-1:0]                    st_word,
  output logic [31:0]                          st_mask
);

  logic [31:0] nt_q [NT_WORDS];
  logic [31:0] bo_q [NUM_GROUPS];
  logic [7:0]  pm_q [NUM_GROUPS];
  logic [7:0]  cm_q [NUM_IRQ];

  int   a, nt_w, bo_w, pm_w, en_w, cm_w, sc_i, sw_i;
  logic nt_hit, bo_hit, pm_hit, en_hit, cm_hit, st_hit, any_hit;
  logic [31:0] rd_n, lane_mask;

  always_comb begin
    a      = int'(addr);
    nt_w   = (a - NT_BASE) >> 2;
    bo_w   = (a - BO_BASE) >> 2;
    pm_w   = (a - PM_BASE) >> 2;
    en_w   = (a - EN_BASE) >> 2;
    cm_w   = (a - CM_BASE) >> 2;
    sc_i   = int'(addr[9:8]);
    sw_i   = int'(addr[4:2]);
    nt_hit = (a >= NT_BASE) && (a < NT_BASE + 4 * NT_WORDS);
    bo_hit = (a >= BO_BASE) && (a < BO_BASE + 4 * NUM_GROUPS);
    pm_hit = (a >= PM_BASE) && (a < PM_BASE + NUM_GROUPS);
    en_hit = (a >= EN_BASE) && (a < EN_BASE + NUM_IRQ / 8);
    cm_hit = (a >= CM_BASE) && (a < CM_BASE + NUM_IRQ);
    st_hit = (a >= ST_BASE) && (a < ST_END) && (addr[7:5] == 3'b000)
             && (sc_i < NUM_CORES) && (sw_i < NUM_WORDS);
    any_hit = nt_hit | bo_hit | pm_hit | en_hit | cm_hit | st_hit;
    lane_mask = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  end

  // pending-word clear request toward the status array
  assign st_we   = we && st_hit;
  assign st_core = addr[8 +: CORE_W];
  assign st_word = addr[2 +: WORD_W];
  assign st_mask = wdata & lane_mask;

  // configuration storage
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NT_WORDS; k++) nt_q[k] <= '0;
      for (int k = 0; k < NUM_GROUPS; k++) begin
        bo_q[k] <= '0;
        pm_q[k] <= '0;
      end
      for (int k = 0; k < NUM_IRQ; k++) cm_q[k] <= '0;
      en_q <= '0;
    end else if (we) begin
      for (int l = 0; l < 4; l++) begin
        if (be[l]) begin
          if (nt_hit) nt_q[nt_w][8*l +: 8] <= wdata[8*l +: 8];
          if (bo_hit) bo_q[bo_w][8*l +: 8] <= wdata[8*l +: 8];
          if (pm_hit) pm_q[pm_w*4 + l] <= wdata[8*l +: 8];
          if (cm_hit) cm_q[cm_w*4 + l] <= wdata[8*l +: 8];
          if (en_hit) en_q[(en_w*4 + l)*8 +: 8] <= wdata[8*l +: 8];
        end
      end
    end
  end

  // enable bits going from 1 to 0 in this write
  always_comb begin
    en_drop = '0;
    if (we && en_hit) begin
      for (int l = 0; l < 4; l++) begin
        if (be[l])
          en_drop[(en_w*4 + l)*8 +: 8] = en_q[(en_w*4 + l)*8 +: 8] & ~wdata[8*l +: 8];
      end
    end
  end

  // selector decode
  genvar gi;
  generate
    for (gi = 0; gi < NUM_IRQ; gi++) begin : g_core
      assign core_sel[gi] = CORE_W'(nib_pick(cm_q[gi][3:0]));
    end
    for (gi = 0; gi < NUM_GROUPS; gi++) begin : g_pin
      assign pin_sel[gi] = nib_pick(pm_q[gi][3:0]);
    end
  endgenerate

  // read mux, registered
  always_comb begin
    rd_n = '0;
    if (nt_hit)      rd_n = nt_q[nt_w];
    else if (bo_hit) rd_n = bo_q[bo_w];
    else if (en_hit) rd_n = en_q[en_w*32 +: 32];
    else if (st_hit) rd_n = st_q[sc_i][sw_i*32 +: 32];
    else if (pm_hit) begin
      for (int l = 0; l < 4; l++) rd_n[8*l +: 8] = pm_q[pm_w*4 + l];
    end else if (cm_hit) begin
      for (int l = 0; l < 4; l++) rd_n[8*l +: 8] = cm_q[cm_w*4 + l];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_n;
  end

  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (rst)
    !$past(any_hit) |-> (rdata == 32'd0));

endmodule

// File: rtl/ext_irq_router_status.sv
module ext_irq_router_status #(
  parameter int NUM_IRQ   = 256,
  parameter int NUM_CORES = 4,
  localparam int NUM_WORDS = NUM_IRQ / 32,
  localparam int CORE_W    = $clog2(NUM_CORES),
  localparam int WORD_W    = $clog2(NUM_WORDS)
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [NUM_IRQ-1:0]                 irq_in,
  input  logic [NUM_IRQ-1:0]                 en_q,
  input  logic [NUM_IRQ-1:0]                 en_drop,
  input  logic [NUM_IRQ-1:0][CORE_W-1:0]     core_sel,
  input  logic                               st_we,
  input  logic [CORE_W-1:0]                  st_core,
  input  logic [WORD_W-1:0]                  st_word,
  input  logic [31:0]                        st_mask,
  output logic [NUM_CORES-1:0][NUM_IRQ-1:0]  st_q
);

  logic [NUM_IRQ-1:0] lvl_q, rise, fall;
  logic [NUM_CORES-1:0][NUM_IRQ-1:0] route_m, set_m, clr_m, w1c_m;

  assign rise = irq_in & ~lvl_q;
  assign fall = ~irq_in & lvl_q;

  always_comb begin
    for (int c = 0; c < NUM_CORES; c++) begin
      w1c_m[c] = '0;
      for (int i = 0; i < NUM_IRQ; i++) begin
        route_m[c][i] = (int'(core_sel[i]) == c);
        set_m[c][i]   = route_m[c][i] & rise[i] & en_q[i];
        clr_m[c][i]   = route_m[c][i] & (fall[i] | en_drop[i]);
      end
      if (st_we && (int'(st_core) == c))
        w1c_m[c][int'(st_word)*32 +: 32] = st_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= '0;
      st_q  <= '0;
    end else begin
      lvl_q <= irq_in;
      for (int c = 0; c < NUM_CORES; c++)
        st_q[c] <= (st_q[c] & ~(clr_m[c] | w1c_m[c])) | set_m[c];
    end
  end

  genvar gc;
  generate
    for (gc = 0; gc < NUM_CORES; gc++) begin : g_chk
      assert_rise_sets_R4: assert property (@(posedge clk) disable iff (rst)
        (|set_m[gc]) |=> ((st_q[gc] & $past(set_m[gc])) == $past(set_m[gc])));
      assert_disabled_ignored_R4: assert property (@(posedge clk) disable iff (rst)
        ((st_q[gc] & ~$past(st_q[gc]) & $past(rise & ~en_q)) == '0));
      assert_fall_clears_R5: assert property (@(posedge clk) disable iff (rst)
        ((st_q[gc] & $past(fall & route_m[gc])) == '0));
      assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (rst)
        ((st_q[gc] & $past(w1c_m[gc] & ~set_m[gc])) == '0));
    end
  endgenerate

endmodule

// File: rtl/ext_irq_router_pins.sv
module ext_irq_router_pins #(
  parameter int NUM_IRQ    = 256,
  parameter int GROUP_SIZE = 32,
  parameter int NUM_CORES  = 4,
  parameter int NUM_PINS   = 8,
  localparam int NUM_GROUPS = NUM_IRQ / GROUP_SIZE
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [NUM_CORES-1:0][NUM_IRQ-1:0]  st_q,
  input  logic [NUM_GROUPS-1:0][1:0]         pin_sel,
  output logic [NUM_CORES*NUM_PINS-1:0]      core_irq
);

  logic [NUM_CORES-1:0][NUM_GROUPS-1:0] grp_any;
  logic [NUM_CORES*NUM_PINS-1:0]        pin_n;

  always_comb begin
    pin_n = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      for (int g = 0; g < NUM_GROUPS; g++) begin
        grp_any[c][g] = |st_q[c][g*GROUP_SIZE +: GROUP_SIZE];
        pin_n[c*NUM_PINS + int'(pin_sel[g])] =
          pin_n[c*NUM_PINS + int'(pin_sel[g])] | grp_any[c][g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) core_irq <= '0;
    else     core_irq <= pin_n;
  end

  genvar gc;
  generate
    for (gc = 0; gc < NUM_CORES; gc++) begin : g_chk
      assert_pin_has_source_R8: assert property (@(posedge clk) disable iff (rst)
        (|core_irq[gc*NUM_PINS +: NUM_PINS]) |-> $past(|st_q[gc]));
      assert_pin_follows_R8: assert property (@(posedge clk) disable iff (rst)
        (|st_q[gc]) |=> (|core_irq[gc*NUM_PINS +: NUM_PINS]));
    end
  endgenerate

endmodule

// File: rtl/ext_irq_router.sv
module ext_irq_router #(
  parameter int NUM_IRQ    = 256,
  parameter int GROUP_SIZE = 32,
  parameter int NUM_CORES  = 4,
  parameter int NUM_PINS   = 8,
  parameter int ADDR_W     = 12,
  localparam int NUM_GROUPS = NUM_IRQ / GROUP_SIZE,
  localparam int NUM_WORDS  = NUM_IRQ / 32,
  localparam int CORE_W     = $clog2(NUM_CORES),
  localparam int WORD_W     = $clog2(NUM_WORDS)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_IRQ-1:0]            irq_in,
  input  logic [ADDR_W-1:0]             reg_addr,
  input  logic [31:0]                   reg_wdata,
  input  logic [3:0]                    reg_be,
  input  logic                          reg_we,
  output logic [31:0]                   reg_rdata,
  output logic [NUM_CORES*NUM_PINS-1:0] core_irq
);

  logic [NUM_CORES-1:0][NUM_IRQ-1:0] st_q;
  logic [NUM_IRQ-1:0]                en_q, en_drop;
  logic [NUM_IRQ-1:0][CORE_W-1:0]    core_sel;
  logic [NUM_GROUPS-1:0][1:0]        pin_sel;
  logic                              st_we;
  logic [CORE_W-1:0]                 st_core;
  logic [WORD_W-1:0]                 st_word;
  logic [31:0]                       st_mask;

  ext_irq_router_regs #(
    .NUM_IRQ(NUM_IRQ), .GROUP_SIZE(GROUP_SIZE),
    .NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst(rst), .addr(reg_addr), .wdata(reg_wdata), .be(reg_be),
    .we(reg_we), .st_q(st_q), .rdata(reg_rdata), .en_q(en_q),
    .en_drop(en_drop), .core_sel(core_sel), .pin_sel(pin_sel),
    .st_we(st_we), .st_core(st_core), .st_word(st_word), .st_mask(st_mask)
  );

  ext_irq_router_status #(
    .NUM_IRQ(NUM_IRQ), .NUM_CORES(NUM_CORES)
  ) u_status (
    .clk(clk), .rst(rst), .irq_in(irq_in), .en_q(en_q), .en_drop(en_drop),
    .core_sel(core_sel), .st_we(st_we), .st_core(st_core),
    .st_word(st_word), .st_mask(st_mask), .st_q(st_q)
  );

  ext_irq_router_pins #(
    .NUM_IRQ(NUM_IRQ), .GROUP_SIZE(GROUP_SIZE),
    .NUM_CORES(NUM_CORES), .NUM_PINS(NUM_PINS)
  ) u_pins (
    .clk(clk), .rst(rst), .st_q(st_q), .pin_sel(pin_sel), .core_irq(core_irq)
  );

endmodule

// File: tb/ext_irq_router_test.sv
`timescale 1ns/1ps
module ext_irq_router_test;

  logic         clk = 1'b0;
  logic         rst;
  logic [255:0] irq_in;
  logic [11:0]  reg_addr;
  logic [31:0]  reg_wdata;
  logic [3:0]   reg_be;
  logic         reg_we;
  logic [31:0]  reg_rdata;
  logic [31:0]  core_irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ext_irq_router uut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_be(reg_be), .reg_we(reg_we),
    .reg_rdata(reg_rdata), .core_irq(core_irq)
  );

  function automatic int pick(input logic [7:0] v);
    for (int b = 0; b < 4; b++) if (v[b]) return b;
    return 0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] b);
    reg_addr = a; reg_wdata = d; reg_be = b; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; reg_be = 4'h0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    rst = 1'b1; irq_in = '0; reg_addr = '0; reg_wdata = '0; reg_be = '0; reg_we = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 core_irq", core_irq, 32'h0);
    rd(12'h0C0, d); check("R1 pin map", d, 32'h0);
    rd(12'h200, d); check("R1 enable", d, 32'h0);
    rd(12'h800, d); check("R1 core map", d, 32'h0);
    rd(12'h0A0, d); check("R1 node type", d, 32'h0);
    rd(12'h400, d); check("R1 pending", d, 32'h0);

    // R10 plain storage, R12 one-cycle read
    wr(12'h0A4, 32'hDEADBEEF, 4'hF);
    rd(12'h0A4, d); check("R10 R12 node type readback", d, 32'hDEADBEEF);
    wr(12'h29C, 32'h11223344, 4'b0101);
    rd(12'h29C, d); check("R10 bounce lanes", d, 32'h00220044);
    settle(); check("R10 no routing effect", core_irq, 32'h0);

    // R11 unmapped
    wr(12'h300, 32'hFFFFFFFF, 4'hF);
    rd(12'h300, d); check("R11 unmapped 0x300", d, 32'h0);
    wr(12'h420, 32'hFFFFFFFF, 4'hF);
    rd(12'h420, d); check("R11 pending hole 0x420", d, 32'h0);
    wr(12'h0C8, 32'hFFFFFFFF, 4'hF);
    rd(12'h0C8, d); check("R11 after pin map", d, 32'h0);
    rd(12'h0A4, d); check("R11 storage untouched", d, 32'hDEADBEEF);

    for (int w = 0; w < 8; w++) wr(12'h200 + 12'(4*w), 32'hFFFFFFFF, 4'hF);
    rd(12'h21C, d); check("R6 enable readback", d, 32'hFFFFFFFF);

    // R2 sweep of pin selector on source 5 (group 0, core 0)
    for (int v = 0; v < 16; v++) begin
      wr(12'h0C0, 32'(v), 4'b0001);
      irq_in[5] = 1'b1; settle();
      check("R2 R4 pin decode", core_irq, 32'h1 << pick(8'(v)));
      irq_in[5] = 1'b0; settle();
      check("R5 fall clears", core_irq, 32'h0);
    end
    irq_in[5] = 1'b1; settle();
    rd(12'h400, d); check("R9 pending core0 word0", d, 32'h20);
    irq_in[5] = 1'b0; settle();

    // R3 sweep of core selector on source 200 (group 6 -> pin 2)
    wr(12'h0C4, 32'h00040000, 4'b0100);
    for (int v = 0; v < 16; v++) begin
      wr(12'h8C8, 32'(v), 4'b0001);
      rd(12'h8C8, d); check("R3 core map readback", d & 32'hFF, 32'(v));
      irq_in[200] = 1'b1; settle();
      check("R3 core decode", core_irq, 32'h1 << (pick(8'(v)) * 8 + 2));
      rd(12'h400 | 12'(pick(8'(v)) << 8) | 12'h018, d);
      check("R9 pending word6 bit8", d, 32'h100);
      irq_in[200] = 1'b0; settle();
      check("R5 fall clears core", core_irq, 32'h0);
    end

    // R4 disabled source ignored, R6 re-enable without edge
    wr(12'h204, 32'h0000FE00, 4'b0010);
    irq_in[40] = 1'b1; settle();
    check("R4 disabled ignored", core_irq, 32'h0);
    rd(12'h404, d); check("R4 disabled pending", d, 32'h0);
    wr(12'h204, 32'h0000FF00, 4'b0010); settle();
    check("R6 re-enable no edge", core_irq, 32'h0);
    irq_in[40] = 1'b0; settle();

    // R6 retract by enable clear
    irq_in[41] = 1'b1; settle();
    check("R6 raised before clear", core_irq, 32'h1);
    wr(12'h204, 32'h0000FD00, 4'b0010); settle();
    check("R6 retract pin", core_irq, 32'h0);
    rd(12'h404, d); check("R6 retract pending", d, 32'h0);
    wr(12'h204, 32'h0000FF00, 4'b0010);
    irq_in[41] = 1'b0; settle();

    // R7 write-one-to-clear, R8 shared pin in one group
    irq_in[70] = 1'b1; irq_in[71] = 1'b1; settle();
    rd(12'h408, d); check("R9 two pending", d, 32'hC0);
    wr(12'h408, 32'h80, 4'b1110);
    rd(12'h408, d); check("R7 masked lane ignored", d, 32'hC0);
    wr(12'h408, 32'h40, 4'hF); settle();
    rd(12'h408, d); check("R7 one cleared", d, 32'h80);
    check("R8 still held", core_irq, 32'h1);
    wr(12'h408, 32'h80, 4'hF); settle();
    check("R7 last cleared", core_irq, 32'h0);
    settle();
    check("R7 stays clear while high", core_irq, 32'h0);
    irq_in[70] = 1'b0; irq_in[71] = 1'b0; settle();

    // R8 shared pin across groups, R2 upper nibble ignored
    wr(12'h0C0, 32'h0000A202, 4'b0011);
    irq_in[5] = 1'b1; irq_in[41] = 1'b1; settle();
    check("R2 R8 shared pin1", core_irq, 32'h2);
    irq_in[5] = 1'b0; settle();
    check("R8 held by other", core_irq, 32'h2);
    irq_in[41] = 1'b0; settle();
    check("R8 last released", core_irq, 32'h0);

    // R3 two cores at once
    wr(12'h804, 32'h00000800, 4'b0010);
    irq_in[5] = 1'b1; irq_in[41] = 1'b1; settle();
    check("R3 split cores", core_irq, (32'h1 << 25) | 32'h2);
    irq_in[5] = 1'b0; irq_in[41] = 1'b0; settle();
    check("R5 both released", core_irq, 32'h0);

    finish_run();
  end

endmodule